// File: doc/BRIEF.md
# Multi-Precision SIMD Vector ALU

This block is the arithmetic core of a vector engine for fixed-point work. Each operation treats one wide register as a row of equal-width lanes, with lanes of 8, 16, 32 or 64 bits chosen per operation. The number of lanes is the register width divided by the lane width, so the default 256-bit register holds 32 byte lanes, 16 halfword lanes, 8 word lanes or 4 doubleword lanes. The block covers lane-wise add, subtract, low-half multiply, shifts, signed compares and signed min/max, plus two whole-vector reductions (sum and max) that produce a 64-bit scalar.

The adder is shared by all four lane widths. The carry chain runs through byte slices and is cut wherever a lane begins. Any vector operation can take its second operand from the scalar input instead of the second vector. The low lane-width bits of the scalar are then copied into every lane. Shifts always take their amount from the scalar input.

Every accepted operation is registered once. A vector result updates the vector output only, and a reduction updates the scalar output only. The untouched output keeps its last value, which lets a sequencer interleave the two kinds of operation without extra storage.

Top module: `simd_vec_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `vec_out` and `scl_out` are cleared to zero at that edge.
- R2: An operation presented with `in_valid` high gives its result on the outputs after the next rising edge, with `out_valid` high for exactly that cycle. With `in_valid` low, `out_valid` is low after the edge.
- R3: The `esz` codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit lanes. Lane `k` occupies bits `[k*EW +: EW]`. Opcode 0 (add) and opcode 1 (subtract a minus b) wrap modulo 2^EW in each lane, and no carry or borrow crosses a lane boundary.
- R4: Opcode 2 (multiply) gives the low EW bits of each lane product.
- R5: Opcode 3 is a logical right shift, opcode 4 an arithmetic right shift and opcode 5 a left shift. The shift amount is the low log2(EW) bits of `scl_in`, whatever the state of `bcast`.
- R6: Opcodes 6 (a < b), 7 (a >= b) and 8 (a == b) compare lanes as signed values. Each lane is written all ones when the condition holds and all zeros when it does not.
- R7: Opcode 9 gives the signed minimum and opcode 10 the signed maximum of each lane pair.
- R8: When `bcast` is high, every lane's second operand is the low EW bits of `scl_in` in place of `vec_b`.
- R9: Opcode 11 writes to `scl_out` the sum, modulo 2^64, of all lanes of `vec_a`, each lane sign-extended to 64 bits.
- R10: Opcode 12 writes to `scl_out` the largest signed lane of `vec_a`, sign-extended to 64 bits.
- R11: A reduction leaves `vec_out` unchanged and a vector operation leaves `scl_out` unchanged. A cycle with `in_valid` low changes neither output.
- R12: Opcodes 13 to 15 write an all-zero `vec_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode |
| esz | input | 2 | Lane width select |
| bcast | input | 1 | Take second operand from the scalar input |
| vec_a | input | VW | First vector operand |
| vec_b | input | VW | Second vector operand |
| scl_in | input | 64 | Scalar operand and shift amount |
| out_valid | output | 1 | Result registered this cycle |
| vec_out | output | VW | Vector result |
| scl_out | output | 64 | Reduction result |

## Verification
The checker assumes that `op`, `esz` and the operands are at known values whenever `in_valid` is high. It also assumes that `rst` is asserted at the first edge, so that its hold properties compare against cleared outputs. The bench drives every input from a task on the falling edge and holds it across the next rising edge. It keeps `in_valid` low between operations, so that each idle cycle also exercises the hold behaviour. The sweep covers every opcode and every lane width, with broadcast both on and off, in a 64-bit configuration. Operands are random and mixed with directed lane-boundary carry, borrow and sign patterns.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_SRA  = 4'd4,
    OP_SLL  = 4'd5,
    OP_LT   = 4'd6,
    OP_GE   = 4'd7,
    OP_EQ   = 4'd8,
    OP_MIN  = 4'd9,
    OP_MAX  = 4'd10,
    OP_RSUM = 4'd11,
    OP_RMAX = 4'd12
  } vop_e;

  localparam int NUM_SIZES = 4;
  localparam int SCL_W     = 64;

  function automatic logic is_reduction(input logic [3:0] code);
    return (code == OP_RSUM) || (code == OP_RMAX);
  endfunction

  function automatic logic is_addsub(input logic [3:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/simd_carry_adder.sv
module simd_carry_adder #(
  parameter int VW = 256
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  logic          sub,
  input  logic [1:0]    esz,
  output logic [VW-1:0] sum
);
  localparam int NB = VW / 8;

  always_comb begin
    logic       carry;
    logic       cin;
    logic       start;
    logic [7:0] bb;
    logic [8:0] part;
    carry = 1'b0;
    sum   = '0;
    for (int i = 0; i < NB; i++) begin
      start = ((i % (1 << esz)) == 0);
      bb    = sub ? ~b[i*8 +: 8] : b[i*8 +: 8];
      cin   = start ? sub : carry;
      part  = {1'b0, a[i*8 +: 8]} + {1'b0, bb} + {8'd0, cin};
      sum[i*8 +: 8] = part[7:0];
      carry = part[8];
    end
  end
endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_alu_pkg::*;
#(
  parameter int VW = 256,
  parameter int EW = 8,
  localparam int SW = $clog2(EW)
) (
  input  logic [3:0]    op,
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  logic [SW-1:0] shamt,
  output logic [VW-1:0] res
);
  localparam int NL = VW / EW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [EW-1:0] xa, xb, lo, r;
    logic          slt, seq;
    assign xa  = a[l*EW +: EW];
    assign xb  = b[l*EW +: EW];
    assign lo  = xa * xb;
    assign slt = $signed(xa) < $signed(xb);
    assign seq = (xa == xb);

    always_comb begin
      case (op)
        OP_MUL:  r = lo;
        OP_SRL:  r = xa >> shamt;
        OP_SRA:  r = $signed(xa) >>> shamt;
        OP_SLL:  r = xa << shamt;
        OP_LT:   r = {EW{slt}};
        OP_GE:   r = {EW{~slt}};
        OP_EQ:   r = {EW{seq}};
        OP_MIN:  r = slt ? xa : xb;
        OP_MAX:  r = slt ? xb : xa;
        default: r = '0;
      endcase
    end
    assign res[l*EW +: EW] = r;
  end
endmodule

// File: rtl/simd_lane_reduce.sv
module simd_lane_reduce #(
  parameter int VW = 256,
  parameter int EW = 8
) (
  input  logic [VW-1:0] a,
  output logic [63:0]   rsum,
  output logic [63:0]   rmax
);
  localparam int NL = VW / EW;

  logic [63:0] ext [NL];

  for (genvar l = 0; l < NL; l++) begin : g_ext
    if (EW == 64) begin : g_full
      assign ext[l] = a[l*EW +: EW];
    end else begin : g_sx
      assign ext[l] = {{(64-EW){a[l*EW+EW-1]}}, a[l*EW +: EW]};
    end
  end

  always_comb begin
    rsum = '0;
    rmax = ext[0];
    for (int l = 0; l < NL; l++) begin
      rsum = rsum + ext[l];
      if ($signed(ext[l]) > $signed(rmax)) rmax = ext[l];
    end
  end
endmodule

// File: rtl/simd_vec_alu.sv
module simd_vec_alu
  import simd_alu_pkg::*;
#(
  parameter int VW = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    esz,
  input  logic          bcast,
  input  logic [VW-1:0] vec_a,
  input  logic [VW-1:0] vec_b,
  input  logic [63:0]   scl_in,
  output logic          out_valid,
  output logic [VW-1:0] vec_out,
  output logic [63:0]   scl_out
);
  logic [VW-1:0] bsrc  [NUM_SIZES];
  logic [VW-1:0] lres  [NUM_SIZES];
  logic [63:0]   rsum  [NUM_SIZES];
  logic [63:0]   rmax  [NUM_SIZES];
  logic [VW-1:0] add_out;
  logic [VW-1:0] vres;
  logic [63:0]   sres;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int EW = 8 << g;
    localparam int SW = $clog2(EW);

    assign bsrc[g] = bcast ? {(VW/EW){scl_in[EW-1:0]}} : vec_b;

    simd_lane_unit #(.VW(VW), .EW(EW)) u_lane (
      .op    (op),
      .a     (vec_a),
      .b     (bsrc[g]),
      .shamt (scl_in[SW-1:0]),
      .res   (lres[g])
    );

    simd_lane_reduce #(.VW(VW), .EW(EW)) u_red (
      .a    (vec_a),
      .rsum (rsum[g]),
      .rmax (rmax[g])
    );
  end

  simd_carry_adder #(.VW(VW)) u_add (
    .a   (vec_a),
    .b   (bsrc[esz]),
    .sub (op == OP_SUB),
    .esz (esz),
    .sum (add_out)
  );

  assign vres = is_addsub(op) ? add_out : lres[esz];
  assign sres = (op == OP_RSUM) ? rsum[esz] : rmax[esz];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      vec_out   <= '0;
      scl_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (is_reduction(op)) scl_out <= sres;
        else                  vec_out <= vres;
      end
    end
  end
endmodule

// File: rtl/simd_vec_alu_chk.sv
module simd_vec_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int VW = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [1:0]    esz,
  input logic          bcast,
  input logic [VW-1:0] vec_a,
  input logic [VW-1:0] vec_b,
  input logic [63:0]   scl_in,
  input logic          out_valid,
  input logic [VW-1:0] vec_out,
  input logic [63:0]   scl_out
);
  function automatic logic lanes_uniform(input logic [VW-1:0] v, input logic [1:0] e);
    for (int i = 0; i < VW/8; i++) begin
      int first;
      first = i - (i % (1 << e));
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
      if (v[first*8 +: 8] != v[i*8 +: 8]) return 1'b0;
    end
    return 1'b1;
  endfunction

  logic is_cmp;
  assign is_cmp = (op == OP_LT) || (op == OP_GE) || (op == OP_EQ);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && vec_out == '0 && scl_out == '0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_CMP_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> lanes_uniform(vec_out, $past(esz))); // R6
  AST_REDUCE_KEEPS_VEC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_reduction(op)) |=> $stable(vec_out)); // R11
  AST_VECTOR_KEEPS_SCL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_reduction(op)) |=> $stable(scl_out)); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(vec_out) && $stable(scl_out))); // R11
  AST_SPARE_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > OP_RMAX) |=> vec_out == '0); // R12
endmodule

bind simd_vec_alu simd_vec_alu_chk #(.VW(VW)) u_chk (.*);

// File: tb/simd_vec_alu_tb.sv
module simd_vec_alu_tb;
  localparam int VW  = 64;
  localparam int CLK = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [3:0]    op;
  logic [1:0]    esz;
  logic          bcast;
  logic [VW-1:0] vec_a, vec_b;
  logic [63:0]   scl_in;
  logic          out_valid;
  logic [VW-1:0] vec_out;
  logic [63:0]   scl_out;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;
  logic [VW-1:0] prev_vec;
  logic [63:0]   prev_scl;

  always #(CLK/2) clk = ~clk;

  simd_vec_alu #(.VW(VW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .esz(esz),
    .bcast(bcast), .vec_a(vec_a), .vec_b(vec_b), .scl_in(scl_in),
    .out_valid(out_valid), .vec_out(vec_out), .scl_out(scl_out)
  );

  function automatic string req_of(input int c);
    case (c)
      0, 1:    return "R3";
      2:       return "R4";
      3, 4, 5: return "R5";
      6, 7, 8: return "R6";
      9, 10:   return "R7";
      11:      return "R9";
      12:      return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [63:0] lane_mask(input int ew);
    return (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
  endfunction

  function automatic logic [63:0] sx(input logic [63:0] x, input int ew);
    logic [63:0] m;
    m = lane_mask(ew);
    return x[ew-1] ? (x | ~m) : x;
  endfunction

  function automatic logic [VW-1:0] mdl_vec(input int c, input int e, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [63:0] s, input logic bc);
    int ew, nl;
    logic [63:0] m, x, y, xs, ys, r, sh;
    logic [VW-1:0] res;
    ew  = 8 << e;
    nl  = VW / ew;
    m   = lane_mask(ew);
    sh  = s & 64'(ew - 1);
    res = '0;
    for (int l = 0; l < nl; l++) begin
      x  = 64'(a >> (l*ew)) & m;
      y  = bc ? (s & m) : (64'(b >> (l*ew)) & m);
      xs = sx(x, ew);
      ys = sx(y, ew);
      case (c)
        0:  r = x + y;
        1:  r = x - y;
        2:  r = x * y;
        3:  r = x >> sh;
        4:  r = $signed(xs) >>> sh;
        5:  r = x << sh;
        6:  r = ($signed(xs) <  $signed(ys)) ? m : 64'd0;
        7:  r = ($signed(xs) >= $signed(ys)) ? m : 64'd0;
        8:  r = (x == y) ? m : 64'd0;
        9:  r = ($signed(xs) < $signed(ys)) ? x : y;
        10: r = ($signed(xs) < $signed(ys)) ? y : x;
        default: r = 64'd0;
      endcase
      res = res | (VW'(r & m) << (l*ew));
    end
    return res;
  endfunction

  function automatic logic [63:0] mdl_scl(input int c, input int e, input logic [VW-1:0] a);
    int ew, nl;
    logic [63:0] m, xs, acc, mx;
    ew  = 8 << e;
    nl  = VW / ew;
    m   = lane_mask(ew);
    acc = 64'd0;
    mx  = sx(64'(a) & m, ew);
    for (int l = 0; l < nl; l++) begin
      xs  = sx(64'(a >> (l*ew)) & m, ew);
      acc = acc + xs;
      if ($signed(xs) > $signed(mx)) mx = xs;
    end
    return (c == 11) ? acc : mx;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input int c, input int e, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [63:0] s, input logic bc);
    logic [VW-1:0] ev;
    logic [63:0]   es;
    string rq;
    @(negedge clk);
    in_valid = 1'b1; op = 4'(c); esz = 2'(e); bcast = bc;
    vec_a = a; vec_b = b; scl_in = s;
    @(negedge clk);
    in_valid = 1'b0;
    rq = (bc && c <= 10 && c != 3 && c != 4 && c != 5) ? "R8" : req_of(c);
    check(out_valid == 1'b1, "R2", "out_valid after op", 64'(out_valid), 64'd1);
    if (c == 11 || c == 12) begin
      es = mdl_scl(c, e, a);
      check(scl_out == es, rq, "scalar result", scl_out, es);
      check(vec_out == prev_vec, "R11", "vec held on reduction", vec_out, prev_vec);
      prev_scl = es;
    end else begin
      ev = mdl_vec(c, e, a, b, s, bc);
      check(vec_out == ev, rq, "vector result", vec_out, ev);
      check(scl_out == prev_scl, "R11", "scl held on vector op", scl_out, prev_scl);
      prev_vec = ev;
    end
    @(negedge clk);
    check(out_valid == 1'b0 && vec_out == prev_vec && scl_out == prev_scl,
          "R11", "idle cycle holds", vec_out, prev_vec);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; esz = '0; bcast = 1'b0;
    vec_a = '0; vec_b = '0; scl_in = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && vec_out == '0 && scl_out == '0, "R1", "reset state",
          vec_out, 64'd0);
    rst = 1'b0;
    prev_vec = '0;
    prev_scl = '0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "no valid when idle", 64'(out_valid), 64'd0);

    // R3 carry and borrow stop at lane boundaries
    run(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 1'b0);
    run(0, 1, 64'h00FF_00FF_FFFF_00FF, 64'h0001_0001_0001_0001, 0, 1'b0);
    run(1, 0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 0, 1'b0);
    run(1, 2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 0, 1'b0);
    run(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 0, 1'b0);
    // R5 shift amount masked to lane width
    run(4, 0, 64'h80F0_7F01_8081_C0FF, 0, 64'd9, 1'b0);
    run(3, 1, 64'h8000_F00F_1234_FFFF, 0, 64'd20, 1'b0);
    // R6 R7 signed lane compares with equal and extreme values
    run(6, 0, 64'h807F_0080_FF01_7F80, 64'h7F80_0080_01FF_7F7F, 0, 1'b0);
    run(8, 1, 64'h8000_1234_FFFF_0000, 64'h8000_1235_FFFF_0001, 0, 1'b0);
    run(9, 2, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 0, 1'b0);
    // R9 R10 reductions over negative lanes
    run(11, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1'b0);
    run(12, 1, 64'h8000_FFFE_8001_FFFF, 0, 0, 1'b0);
    run(12, 3, 64'h8000_0000_0000_0000, 0, 0, 1'b0);

    for (int e = 0; e < 4; e++) begin
      for (int c = 0; c < 16; c++) begin
        for (int k = 0; k < 12; k++) begin
          logic [VW-1:0] ra, rb;
          logic [63:0]   rs;
          ra = {$urandom, $urandom};
          rb = (k % 4 == 3) ? ra : {$urandom, $urandom};
          rs = {$urandom, $urandom};
          run(c, e, ra, rb, rs, k[0]);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule